// File: doc/BRIEF.md
# Eight-Line Fixed-Priority Interrupt Controller

This block collects up to eight peripheral interrupt lines and presents one request output to a processor. A rising edge on a line is remembered as pending. A mask register lets software silence individual lines. A fixed-priority resolver picks the lowest-numbered unmasked pending line. The request output is raised only when that line outranks every line already being serviced.

When the processor pulses its acknowledge input, the controller does three things for the winning line. It drives a type number on an 8-bit output, marks the line as in service and drops its pending flag. The type number is a fixed base of 08H plus the line number.

Software reaches two byte-wide registers over a small write/read port. The mask sits at I/O address 21H and can be read back. The command register sits at address 20H. Writing 20H to it ends the highest-priority service in progress, which lets requests of equal or lower priority through again.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the mask reads FFH (all lines disabled), nothing is pending or in service, `int_out` is low and `vec_out` is 00H.
- R2: A line becomes pending on a 0-to-1 transition of its `req_in` bit. A level that stays high after acknowledge does not raise a new request.
- R3: Mask bit n governs line n, with 0 = enabled and 1 = disabled. The mask is written by a bus write to address 21H. A masked line that goes pending keeps its pending flag and raises `int_out` as soon as its mask bit is cleared.
- R4: Among unmasked pending lines, line 0 has the highest priority and line 7 the lowest.
- R5: `int_out` is high exactly when the best unmasked pending line has a lower index than every in-service line. A line of equal or lower priority than one in service stays blocked.
- R6: When `int_ack` is high for one cycle while `int_out` is high, `vec_out` shows 08H + n on the following cycle, where n is the winning line. Line n becomes in service and its pending flag clears.
- R7: A bus write of 20H to address 20H clears only the highest-priority in-service bit.
- R8: Any other value written to address 20H, and any write to an address other than 20H or 21H, changes neither the mask nor the service state.
- R9: `bus_rdata` returns the mask while `bus_addr` is 21H, and 00H for every other address.
- R10: An acknowledge while `int_out` is low changes no pending or in-service state, and `vec_out` shows 0FH (the lowest line's type).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_in | input | 8 | Peripheral request lines, bit n = line n |
| bus_addr | input | 8 | I/O address of the register port |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| int_ack | input | 1 | Processor acknowledge pulse |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Type number, valid the cycle after acknowledge |

## Verification
The assertions check four things on every cycle:
- A mask write lands as written.
- A raised request always has an unmasked pending line behind it.
- An acknowledge of a raised request adds exactly one in-service bit and yields a type inside the 08H–0FH range.
- A command write of the end code removes exactly one in-service bit, and an unanswered acknowledge leaves the service state untouched.

Some behaviours depend on which line was chosen and on earlier history, so only the directed scenarios can show them:
- the exact type number for a given mix of lines;
- a line blocked behind one in service, and nested service ending in the correct order;
- a held level that must not retrigger;
- a masked request surviving until it is unmasked.

// File: rtl/intc_pkg.sv
package intc_pkg;

  // Index of the lowest set bit, 0 when the vector is empty.
  function automatic int lowest_set(input logic [31:0] v);
    int r;
    r = 0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

  // Type number reported for a line.
  function automatic logic [31:0] type_of(input logic [31:0] base, input int idx);
    return base + 32'(idx);
  endfunction

endpackage

// File: rtl/intc_busregs.sv
module intc_busregs #(
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 8,
  parameter int          N         = 8,
  parameter logic [7:0]  CMD_ADDR  = 8'h20,
  parameter logic [7:0]  MASK_ADDR = 8'h21,
  parameter logic [7:0]  EOI_CODE  = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [N-1:0]      mask_q,
  output logic              eoi_hit,
  output logic [DATA_W-1:0] bus_rdata
);
  logic sel_mask, sel_cmd;

  assign sel_mask = (bus_addr == ADDR_W'(MASK_ADDR));
  assign sel_cmd  = (bus_addr == ADDR_W'(CMD_ADDR));
  assign eoi_hit  = bus_wr && sel_cmd && (bus_wdata == DATA_W'(EOI_CODE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                mask_q <= '1;
    else if (bus_wr && sel_mask) mask_q <= bus_wdata[N-1:0];
  end

  assign bus_rdata = sel_mask ? DATA_W'(mask_q) : '0;
endmodule

// File: rtl/intc_resolver.sv
module intc_resolver #(
  parameter int N     = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     pend_q,
  input  logic [N-1:0]     mask_q,
  input  logic [N-1:0]     isr_q,
  output logic             win_valid,
  output logic [IDX_W-1:0] win_idx,
  output logic             isr_valid,
  output logic [IDX_W-1:0] isr_idx,
  output logic             int_req
);
  logic [N-1:0] eligible;

  assign eligible  = pend_q & ~mask_q;
  assign win_valid = |eligible;
  assign win_idx   = IDX_W'(intc_pkg::lowest_set(32'(eligible)));
  assign isr_valid = |isr_q;
  assign isr_idx   = IDX_W'(intc_pkg::lowest_set(32'(isr_q)));
  assign int_req   = win_valid && (!isr_valid || (win_idx < isr_idx));
endmodule

// File: rtl/intc_service.sv
module intc_service #(
  parameter int         N      = 8,
  parameter int         DATA_W = 8,
  parameter logic [7:0] BASE   = 8'h08,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      req_in,
  input  logic              int_ack,
  input  logic              int_req,
  input  logic [IDX_W-1:0]  win_idx,
  input  logic              eoi_hit,
  input  logic              isr_valid,
  input  logic [IDX_W-1:0]  isr_idx,
  output logic [N-1:0]      pend_q,
  output logic [N-1:0]      isr_q,
  output logic [DATA_W-1:0] vec_out,
  output logic              ack_take
);
  logic [N-1:0] req_q, req_rise, ack_clr, eoi_clr;

  assign req_rise = req_in & ~req_q;
  assign ack_take = int_ack && int_req;
  assign ack_clr  = ack_take ? (N'(1) << win_idx) : '0;
  assign eoi_clr  = (eoi_hit && isr_valid) ? (N'(1) << isr_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= '0;
      pend_q  <= '0;
      isr_q   <= '0;
      vec_out <= '0;
    end else begin
      req_q  <= req_in;
      pend_q <= (pend_q & ~ack_clr) | req_rise;
      isr_q  <= (isr_q & ~eoi_clr) | ack_clr;
      if (int_ack) begin
        if (ack_take) vec_out <= DATA_W'(intc_pkg::type_of(32'(BASE), int'(win_idx)));
        else          vec_out <= DATA_W'(intc_pkg::type_of(32'(BASE), N - 1));
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int         N         = 8,
  parameter int         ADDR_W    = 8,
  parameter int         DATA_W    = 8,
  parameter logic [7:0] BASE      = 8'h08,
  parameter logic [7:0] CMD_ADDR  = 8'h20,
  parameter logic [7:0] MASK_ADDR = 8'h21,
  parameter logic [7:0] EOI_CODE  = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      req_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              int_ack,
  output logic              int_out,
  output logic [DATA_W-1:0] vec_out
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]     mask_q, pend_q, isr_q;
  logic             eoi_hit, win_valid, isr_valid, ack_take;
  logic [IDX_W-1:0] win_idx, isr_idx;

  intc_busregs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N(N),
    .CMD_ADDR(CMD_ADDR), .MASK_ADDR(MASK_ADDR), .EOI_CODE(EOI_CODE)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .mask_q(mask_q), .eoi_hit(eoi_hit), .bus_rdata(bus_rdata)
  );

  intc_resolver #(.N(N)) res_i (
    .pend_q(pend_q), .mask_q(mask_q), .isr_q(isr_q),
    .win_valid(win_valid), .win_idx(win_idx),
    .isr_valid(isr_valid), .isr_idx(isr_idx), .int_req(int_out)
  );

  intc_service #(.N(N), .DATA_W(DATA_W), .BASE(BASE)) svc_i (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .int_ack(int_ack),
    .int_req(int_out), .win_idx(win_idx), .eoi_hit(eoi_hit),
    .isr_valid(isr_valid), .isr_idx(isr_idx),
    .pend_q(pend_q), .isr_q(isr_q), .vec_out(vec_out), .ack_take(ack_take)
  );
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int         N         = 8,
  parameter int         ADDR_W    = 8,
  parameter int         DATA_W    = 8,
  parameter logic [7:0] BASE      = 8'h08,
  parameter logic [7:0] MASK_ADDR = 8'h21
) (
  input logic              clk,
  input logic              rst_n,
  input logic              int_ack,
  input logic              int_out,
  input logic              ack_take,
  input logic              eoi_hit,
  input logic              win_valid,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [N-1:0]      mask_q,
  input logic [N-1:0]      pend_q,
  input logic [N-1:0]      isr_q,
  input logic [DATA_W-1:0] vec_out
);
  // R3
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(MASK_ADDR)) |=> (mask_q == $past(bus_wdata[N-1:0])));

  // R5
  req_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> (((pend_q & ~mask_q) != '0) && win_valid));

  // R6
  ack_marks_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && int_out && !eoi_hit) |=> ($countones(isr_q) == $countones($past(isr_q)) + 1));

  // R6
  ack_type_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> ((vec_out >= DATA_W'(BASE)) && (vec_out < DATA_W'(BASE) + DATA_W'(N))));

  // R7
  eoi_clears_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_hit && !int_ack && isr_q != '0) |=> ($countones(isr_q) + 1 == $countones($past(isr_q))));

  // R10
  spurious_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && !int_out && !eoi_hit) |=>
      ($stable(isr_q) && vec_out == DATA_W'(BASE) + DATA_W'(N - 1)));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
  .N(N), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE(BASE), .MASK_ADDR(MASK_ADDR)
) chk_i (
  .clk(clk), .rst_n(rst_n), .int_ack(int_ack), .int_out(int_out),
  .ack_take(ack_take), .eoi_hit(eoi_hit), .win_valid(win_valid),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .mask_q(mask_q), .pend_q(pend_q), .isr_q(isr_q), .vec_out(vec_out)
);

// File: tb/irq_prio_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_in = '0;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       int_ack = 1'b0;
  logic       int_out;
  logic [7:0] vec_out;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  irq_prio_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .int_ack(int_ack), .int_out(int_out), .vec_out(vec_out)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_int(input string req, input logic exp);
    check(req, {7'd0, int_out}, {7'd0, exp});
  endtask

  task automatic pulse_req(input logic [7:0] lines);
    @(negedge clk) req_in = lines;
    @(negedge clk) req_in = '0;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk) begin bus_addr = a; bus_wdata = d; bus_wr = 1'b1; end
    @(negedge clk) begin bus_wr = 1'b0; bus_addr = '0; end
  endtask

  task automatic bus_read_check(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk) bus_addr = a;
    #1 check(req, bus_rdata, exp);
    bus_addr = '0;
  endtask

  task automatic ack_check(input string req, input logic [7:0] exp);
    @(negedge clk) int_ack = 1'b1;
    @(negedge clk) int_ack = 1'b0;
    check(req, vec_out, exp);
  endtask

  task automatic t_reset;
    check_int("R1", 1'b0);
    check("R1", vec_out, 8'h00);
    bus_read_check("R1", 8'h21, 8'hFF);
    bus_read_check("R9", 8'h22, 8'h00);
    bus_read_check("R9", 8'h20, 8'h00);
  endtask

  task automatic t_mask;
    pulse_req(8'h04);
    check_int("R3", 1'b0);
    bus_write(8'h21, 8'hFB);
    check_int("R3", 1'b1);
    bus_read_check("R9", 8'h21, 8'hFB);
    ack_check("R6", 8'h0A);
    check_int("R6", 1'b0);
    bus_write(8'h20, 8'h20);
    check_int("R7", 1'b0);
    bus_write(8'h21, 8'h00);
  endtask

  task automatic t_priority;
    pulse_req(8'h90);
    check_int("R4", 1'b1);
    ack_check("R4", 8'h0C);
    check_int("R5", 1'b0);
    pulse_req(8'h02);
    check_int("R5", 1'b1);
    ack_check("R4", 8'h09);
    check_int("R5", 1'b0);
    bus_write(8'h20, 8'h60);
    check_int("R8", 1'b0);
    bus_write(8'h20, 8'h20);
    check_int("R7", 1'b0);
    bus_write(8'h20, 8'h20);
    check_int("R7", 1'b1);
    ack_check("R6", 8'h0F);
    bus_write(8'h20, 8'h20);
    bus_write(8'h22, 8'hFF);
    bus_read_check("R8", 8'h21, 8'h00);
  endtask

  task automatic t_spurious;
    ack_check("R10", 8'h0F);
    check_int("R10", 1'b0);
    pulse_req(8'h08);
    check_int("R10", 1'b1);
    ack_check("R10", 8'h0B);
    bus_write(8'h20, 8'h20);
  endtask

  task automatic t_edge;
    @(negedge clk) req_in = 8'h40;
    @(negedge clk);
    check_int("R2", 1'b1);
    ack_check("R2", 8'h0E);
    bus_write(8'h20, 8'h20);
    check_int("R2", 1'b0);
    @(negedge clk) req_in = '0;
    bus_write(8'h21, 8'hFF);
    pulse_req(8'h01);
    check_int("R3", 1'b0);
    bus_write(8'h21, 8'h00);
    check_int("R3", 1'b1);
    ack_check("R6", 8'h08);
    bus_write(8'h20, 8'h20);
    check_int("R7", 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask();
    t_priority();
    t_spurious();
    t_edge();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule